// File: doc/BRIEF.md
# Puzzle Frame Receiver with Signed Checksum

This block sits behind a serial byte receiver and turns a stream of bytes into a stored puzzle grid. A start pulse gives the side length S of the square grid (1 to MAX_SIDE). The next S*S accepted bytes are cell values in row-major order from the top-left cell. Each one becomes a single write on a cell-memory write port, with a flag that marks the cell as empty when its value is zero. The byte after the last cell is a checksum byte. It closes the frame.

While the cells arrive, the block keeps a running checksum. A cell whose row plus column is even adds its value, and a cell whose row plus column is odd subtracts its value. Only the low 8 bits are kept. When the checksum byte arrives, the block pulses a frame-complete strobe and reports whether the received byte matched. The solver downstream takes the grid only when the match is reported. A cell value larger than S raises a sticky range-error flag. The frame is still consumed so that byte counting stays aligned.

Top module: `puzzle_frame_rx`

## Requirements
- R1: After reset, cell_we, frame_done, checksum_ok and range_err are low, and bytes are ignored until a start pulse arrives.
- R2: A start pulse loads the side length S and clears the running checksum, checksum_ok, range_err and the cell position, so that the next byte is cell (0,0).
- R3: Each cell byte accepted while cells are expected produces exactly one cell_we pulse one cycle later, with cell_addr = row*S + col in row-major order, which runs 0 to S*S-1.
- R4: With each write, cell_value carries the received byte and cell_empty is 1 exactly when that byte is zero.
- R5: The byte that follows the S*S-th cell is taken as the checksum and produces no cell write.
- R6: One cycle after the checksum byte, frame_done is high for exactly one cycle. checksum_ok is 1 when the byte equals the low 8 bits of (sum of cells with even row+col) minus (sum of cells with odd row+col), and 0 otherwise. checksum_ok holds until the next start.
- R7: Bytes that arrive after the checksum byte produce no write and no frame_done until the next start pulse.
- R8: A cell value greater than S sets range_err one cycle after that byte. range_err stays set until the next start. The frame continues to be parsed normally.
- R9: A start pulse takes priority over a byte strobe in the same cycle. That byte is dropped, and a start in the middle of a frame abandons the old frame.
- R10: Cycles with rx_valid low change nothing, so gaps between bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new frame |
| start_side | input | SIDE_W | Grid side length S, sampled with start |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_byte | input | 8 | Received byte |
| cell_we | output | 1 | Cell memory write enable |
| cell_addr | output | ADDR_W | Cell memory address, row*S+col |
| cell_value | output | 8 | Cell value written |
| cell_empty | output | 1 | Cell value is zero |
| frame_done | output | 1 | One-cycle pulse after the checksum byte |
| checksum_ok | output | 1 | Checksum matched (valid from frame_done) |
| range_err | output | 1 | Sticky: some cell exceeded S |

## Verification
A start pulse and a byte strobe can land in the same cycle. The bench provokes this by raising start together with rx_valid in the middle of a frame. It judges the result from the scoreboard: the colliding byte must produce no write, and the new frame must start again at address 0 and close with a correct checksum. A range error and its cell write also fall in the same cycle. The bench checks this through the scoreboard write entry and the flag seen on that frame.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CELLS    = 2'd1,
    ST_CHECKSUM = 2'd2,
    ST_DONE     = 2'd3
  } pfr_state_t;
endpackage

// File: rtl/pfr_cursor.sv
// Row/column walker for a square grid: linear address and checkerboard parity.
module pfr_cursor #(
  parameter int SIDE_W = 7,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic [SIDE_W-1:0] side,
  output logic [ADDR_W-1:0] addr,
  output logic              odd_cell,
  output logic              last_cell
);
  logic [SIDE_W-1:0] col_q, row_q;
  logic [ADDR_W-1:0] addr_q;
  logic              row_par_q, col_par_q;
  logic              col_wrap;

  assign col_wrap  = (col_q == side - SIDE_W'(1));
  assign last_cell = col_wrap && (row_q == side - SIDE_W'(1));
  assign addr      = addr_q;
  assign odd_cell  = row_par_q ^ col_par_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      col_q     <= '0;
      row_q     <= '0;
      addr_q    <= '0;
      row_par_q <= 1'b0;
      col_par_q <= 1'b0;
    end else if (advance) begin
      addr_q <= addr_q + ADDR_W'(1);
      if (col_wrap) begin
        col_q     <= '0;
        col_par_q <= 1'b0;
        row_q     <= row_q + SIDE_W'(1);
        row_par_q <= ~row_par_q;
      end else begin
        col_q     <= col_q + SIDE_W'(1);
        col_par_q <= ~col_par_q;
      end
    end
  end

  // R3: consecutive cells take consecutive addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  // R2: a restart returns the walker to the top-left cell
  a_r2_restart_origin: assert property (@(posedge clk) disable iff (rst)
    restart |=> (addr_q == '0 && !odd_cell));
endmodule

// File: rtl/pfr_sum.sv
// Modulo-256 accumulator that adds or subtracts each value.
module pfr_sum #(
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add_en,
  input  logic             negate,
  input  logic [SUM_W-1:0] value,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] sum_q;
  assign sum = sum_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  sum_q <= '0;
    else if (add_en)   sum_q <= negate ? (sum_q - value) : (sum_q + value);
  end

  // R10: the checksum moves only when a cell is added
  a_r10_sum_hold: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !clear) |=> $stable(sum_q));
endmodule

// File: rtl/puzzle_frame_rx.sv
module puzzle_frame_rx #(
  parameter int MAX_SIDE = 81,
  parameter int SIDE_W   = $clog2(MAX_SIDE + 1),
  parameter int ADDR_W   = $clog2(MAX_SIDE * MAX_SIDE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIDE_W-1:0] start_side,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              cell_we,
  output logic [ADDR_W-1:0] cell_addr,
  output logic [7:0]        cell_value,
  output logic              cell_empty,
  output logic              frame_done,
  output logic              checksum_ok,
  output logic              range_err
);
  import pfr_pkg::*;

  pfr_state_t        state_q;
  logic [SIDE_W-1:0] side_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              odd_cell, last_cell;
  logic [7:0]        run_sum;
  logic              take_cell, take_sum, too_big;

  assign take_cell = !start && rx_valid && (state_q == ST_CELLS);
  assign take_sum  = !start && rx_valid && (state_q == ST_CHECKSUM);
  assign too_big   = int'(rx_byte) > int'(side_q);

  pfr_cursor #(.SIDE_W(SIDE_W), .ADDR_W(ADDR_W)) u_cursor (
    .clk(clk), .rst(rst), .restart(start), .advance(take_cell),
    .side(side_q), .addr(cur_addr), .odd_cell(odd_cell), .last_cell(last_cell)
  );

  pfr_sum #(.SUM_W(8)) u_sum (
    .clk(clk), .rst(rst), .clear(start), .add_en(take_cell),
    .negate(odd_cell), .value(rx_byte), .sum(run_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      side_q  <= SIDE_W'(1);
    end else if (start) begin
      state_q <= ST_CELLS;
      side_q  <= start_side;
    end else if (take_cell && last_cell) begin
      state_q <= ST_CHECKSUM;
    end else if (take_sum) begin
      state_q <= ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_we     <= 1'b0;
      cell_addr   <= '0;
      cell_value  <= '0;
      cell_empty  <= 1'b0;
      frame_done  <= 1'b0;
      checksum_ok <= 1'b0;
      range_err   <= 1'b0;
    end else begin
      cell_we    <= take_cell;
      frame_done <= take_sum;
      if (take_cell) begin
        cell_addr  <= cur_addr;
        cell_value <= rx_byte;
        cell_empty <= (rx_byte == 8'd0);
      end
      if (start)         checksum_ok <= 1'b0;
      else if (take_sum) checksum_ok <= (rx_byte == run_sum);
      if (start)                     range_err <= 1'b0;
      else if (take_cell && too_big) range_err <= 1'b1;
    end
  end

  // R6: frame_done is a single-cycle pulse, never alongside a write
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  a_r5_no_write_on_done: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !cell_we);
  // R7: after the frame closes, bytes have no effect
  a_r7_done_ignores: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !start) |=> (!cell_we && !frame_done));
  // R8: range error is sticky between starts
  a_r8_range_sticky: assert property (@(posedge clk) disable iff (rst)
    (range_err && !start) |=> range_err);
  // R9: a start cycle never produces a write in the next cycle
  a_r9_start_wins: assert property (@(posedge clk) disable iff (rst)
    start |=> !cell_we);
  // R1: nothing is written before the first start
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> !cell_we);
endmodule

// File: tb/puzzle_frame_rx_tb.sv
`timescale 1ns/1ps
module puzzle_frame_rx_tb;
  localparam int MAX_SIDE = 81;
  localparam int SIDE_W   = $clog2(MAX_SIDE + 1);
  localparam int ADDR_W   = $clog2(MAX_SIDE * MAX_SIDE + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SIDE_W-1:0] start_side = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic cell_we, cell_empty, frame_done, checksum_ok, range_err;
  logic [ADDR_W-1:0] cell_addr;
  logic [7:0] cell_value;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int exp_addr[$];
  int exp_val[$];
  bit exp_ok[$];

  always #4 clk = ~clk;

  puzzle_frame_rx #(.MAX_SIDE(MAX_SIDE)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_side(start_side),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .cell_we(cell_we),
    .cell_addr(cell_addr), .cell_value(cell_value), .cell_empty(cell_empty),
    .frame_done(frame_done), .checksum_ok(checksum_ok), .range_err(range_err)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares outputs with the scoreboard away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cell_we) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R7/R5/R9 unexpected write addr", int'(cell_addr), -1);
        end else begin
          int ea, ev;
          ea = exp_addr.pop_front();
          ev = exp_val.pop_front();
          chk(int'(cell_addr) == ea, "R3 address", int'(cell_addr), ea);
          chk(int'(cell_value) == ev, "R4 value", int'(cell_value), ev);
          chk(cell_empty == (ev == 0), "R4 empty flag", int'(cell_empty), int'(ev == 0));
        end
      end
      if (frame_done) begin
        if (exp_ok.size() == 0) begin
          chk(1'b0, "R7 unexpected frame_done", 1, 0);
        end else begin
          bit eo;
          eo = exp_ok.pop_front();
          chk(checksum_ok == eo, "R6 checksum_ok", int'(checksum_ok), int'(eo));
        end
      end
    end
  end

  task automatic send_byte(input int b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = 8'(b);
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic do_start(input int side, input bit with_byte, input int b);
    @(negedge clk);
    start = 1'b1;
    start_side = SIDE_W'(side);
    rx_valid = with_byte;
    rx_byte = 8'(b);
    @(posedge clk);
    #1 start = 1'b0;
    rx_valid = 1'b0;
  endtask

  function automatic int cellv(input int i, input int side, input int seed);
    return (i * 7 + seed) % (side + 1);
  endfunction

  // Driver: pushes expectations, sends cells and the checksum
  task automatic send_cells(input int side, input int seed, input int gap,
                            input bit bad, input int inj);
    int sum = 0;
    for (int r = 0; r < side; r++) begin
      for (int c = 0; c < side; c++) begin
        int i, v;
        i = r * side + c;
        v = (i == inj) ? side + 1 : cellv(i, side, seed);
        if (((r + c) % 2) == 0) sum += v; else sum -= v;
        exp_addr.push_back(i);
        exp_val.push_back(v);
        send_byte(v, (gap > 0 && (i % 3 == 1)) ? gap : 0);
      end
    end
    sum = sum & 255;
    exp_ok.push_back(!bad);
    send_byte(bad ? ((sum + 1) & 255) : sum, gap);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!cell_we, "R1 cell_we", int'(cell_we), 0);
    chk(!frame_done, "R1 frame_done", int'(frame_done), 0);
    chk(!checksum_ok, "R1 checksum_ok", int'(checksum_ok), 0);
    chk(!range_err, "R1 range_err", int'(range_err), 0);
    // R1: bytes before any start are ignored (monitor flags any write)
    send_byte(5, 0);
    send_byte(0, 0);
    settle();
    chk(!range_err, "R1 idle byte range_err", int'(range_err), 0);

    // R3 R4 R6: side 4, back to back, good checksum
    do_start(4, 1'b0, 0);
    send_cells(4, 3, 0, 1'b0, -1);
    settle();
    chk(checksum_ok, "R6 ok held after done", int'(checksum_ok), 1);
    chk(!range_err, "R8 no range error", int'(range_err), 0);

    // R10 R6: side 9 with gaps, corrupted checksum
    do_start(9, 1'b0, 0);
    send_cells(9, 1, 2, 1'b1, -1);
    settle();
    chk(!checksum_ok, "R6 bad checksum", int'(checksum_ok), 0);
    // R7: bytes after the checksum do nothing
    send_byte(1, 0);
    send_byte(0, 1);
    send_byte(9, 0);
    settle();
    chk(!checksum_ok, "R7 state unchanged", int'(checksum_ok), 0);

    // R8: value above side raises sticky flag, frame still parsed
    do_start(3, 1'b0, 0);
    send_cells(3, 2, 0, 1'b0, 4);
    settle();
    chk(range_err, "R8 range_err set", int'(range_err), 1);
    chk(checksum_ok, "R8 frame still closes ok", int'(checksum_ok), 1);
    // R2: start clears flags
    do_start(2, 1'b0, 0);
    @(negedge clk);
    chk(!range_err, "R2 range_err cleared", int'(range_err), 0);
    chk(!checksum_ok, "R2 checksum_ok cleared", int'(checksum_ok), 0);

    // R9: start mid-frame, colliding with a byte strobe
    do_start(4, 1'b0, 0);
    for (int i = 0; i < 5; i++) begin
      exp_addr.push_back(i);
      exp_val.push_back(cellv(i, 4, 0));
      send_byte(cellv(i, 4, 0), 0);
    end
    do_start(2, 1'b1, 2);
    send_cells(2, 5, 0, 1'b0, -1);
    settle();
    chk(checksum_ok, "R9 restarted frame ok", int'(checksum_ok), 1);

    // R3 R5: side 1 boundary
    do_start(1, 1'b0, 0);
    send_cells(1, 1, 1, 1'b0, -1);
    settle();

    chk(exp_addr.size() == 0, "R3 all writes seen", exp_addr.size(), 0);
    chk(exp_ok.size() == 0, "R6 all frames done", exp_ok.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule